// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Unit

This block sums a stream of unsigned products. Each accepted beat multiplies its two operands and folds the product into a running total. The total is stored in redundant form, as a sum register and a carry register. A beat therefore adds only carry-save compressor delay, with no carry chain across the accumulator width. The partial products are reduced to a sum and carry pair by a chain of 3:2 compressor rows. That pair meets the stored pair in a four-input merge, built from two compressor layers.

A beat that marks the start of a stream discards the stored pair in the same cycle that its own product is loaded. The output is the stored pair resolved by one carry-propagate addition: sum plus carry moved up one bit position. The accumulator is never rewritten in resolved form. A one-cycle done pulse marks the cycle in which the output holds the total of a stream whose final beat has just been accepted. The accumulator is 2·OP_W + GUARD_W bits wide, so 2^GUARD_W worst-case products fit without wraparound.

Top module: `csmac_unit`

## Requirements
- R1: While rst_ni is low and after it rises, before any accepted beat, result_o is 0 and done_o is 0.
- R2: done_o is 1 in exactly the cycles that follow a clock edge at which valid_i and last_i were both 1.
- R3: In the cycle after an accepted beat (valid_i = 1) without first_i, result_o equals its previous value plus a_i·b_i, unsigned, modulo 2^ACC_W.
- R4: In the cycle after an accepted beat with first_i = 1, result_o equals that beat's a_i·b_i alone, whatever total preceded it.
- R5: A cycle with valid_i = 0 leaves result_o unchanged.
- R6: A beat with first_i and last_i both 1 gives a stream of one item: result_o is its product and done_o pulses.
- R7: 2^GUARD_W beats of all-ones operands (255·255 each with OP_W = 8, GUARD_W = 4) total 1040400 without wraparound.
- R8: After a done pulse, a beat without first_i continues from the previous total instead of restarting at zero.
- R9: first_i and last_i have no effect while valid_i is 0: no restart of the total and no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Beat carries an operand pair to accumulate |
| first_i | input | 1 | Beat starts a new stream, discarding the stored total |
| last_i | input | 1 | Beat ends the stream |
| a_i | input | OP_W | Unsigned multiplicand |
| b_i | input | OP_W | Unsigned multiplier |
| result_o | output | ACC_W | Resolved running total (2·OP_W + GUARD_W bits) |
| done_o | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The output is resolved from the stored pair every cycle. A faulty compressor bit, a dropped carry shift or a missed clear therefore appears on result_o in the cycle right after the beat that caused it. The fault does not wait for the end of the stream. Comparing result_o after every beat against a running reference total finds such a fault within one cycle. Watching result_o across idle beats that carry first_i or last_i shows whether the state was disturbed when it should not have been. A carry lost off the top of the accumulator only shows for large totals, so a full run of worst-case operands is needed.

// File: rtl/csmac_pkg.sv
package csmac_pkg;
  parameter int unsigned OP_W_DEF    = 8;
  parameter int unsigned GUARD_W_DEF = 4;

  function automatic int unsigned acc_width(input int unsigned op_w, input int unsigned guard_w);
    return 2 * op_w + guard_w;
  endfunction
endpackage

// File: rtl/csa_row.sv
// Bank of independent 3:2 compressors; c_o is unweighted (bit i has weight 2^(i+1))
module csa_row #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign c_o[i] = (x_i[i] & y_i[i]) | (y_i[i] & z_i[i]) | (x_i[i] & z_i[i]);
  end
endmodule

// File: rtl/pp_tree.sv
// Partial products reduced to a weighted pair: value = ps_o + pc_o
module pp_tree #(
  parameter int unsigned OP_W = 8,
  localparam int unsigned W   = 2 * OP_W
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [W-1:0]    ps_o,
  output logic [W-1:0]    pc_o
);
  logic [W-1:0] pp    [OP_W];
  logic [W-1:0] s_v   [OP_W-1];
  logic [W-1:0] cw_v  [OP_W-1];

  for (genvar k = 0; k < OP_W; k++) begin : g_pp
    assign pp[k] = b_i[k] ? (W'(a_i) << k) : '0;
  end

  assign s_v[0]  = pp[0];
  assign cw_v[0] = pp[1];

  for (genvar k = 1; k < OP_W - 1; k++) begin : g_stage
    logic [W-1:0] c_raw;
    csa_row #(.W(W)) u_csa (
      .x_i(s_v[k-1]), .y_i(cw_v[k-1]), .z_i(pp[k+1]),
      .s_o(s_v[k]),   .c_o(c_raw)
    );
    assign cw_v[k] = c_raw << 1;
  end

  assign ps_o = s_v[OP_W-2];
  assign pc_o = cw_v[OP_W-2];
endmodule

// File: rtl/cs_merge.sv
// Four-input merge: stored pair (carry unweighted) plus weighted product pair
module cs_merge #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] acc_s_i,
  input  logic [W-1:0] acc_c_i,
  input  logic [W-1:0] prod_s_i,
  input  logic [W-1:0] prod_c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] l1_s, l1_c;

  csa_row #(.W(W)) u_l1 (
    .x_i(acc_s_i), .y_i(acc_c_i << 1), .z_i(prod_s_i),
    .s_o(l1_s),    .c_o(l1_c)
  );

  csa_row #(.W(W)) u_l2 (
    .x_i(l1_s), .y_i(l1_c << 1), .z_i(prod_c_i),
    .s_o(s_o),  .c_o(c_o)
  );
endmodule

// File: rtl/csmac_unit.sv
module csmac_unit
  import csmac_pkg::*;
#(
  parameter int unsigned OP_W    = OP_W_DEF,
  parameter int unsigned GUARD_W = GUARD_W_DEF,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned ACC_W  = acc_width(OP_W, GUARD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o
);
  logic [PROD_W-1:0] tree_s, tree_c;
  logic [ACC_W-1:0]  st_s, st_c;
  logic [ACC_W-1:0]  base_s, base_c;
  logic [ACC_W-1:0]  nx_s, nx_c;
  logic              done_q;

  pp_tree #(.OP_W(OP_W)) u_tree (
    .a_i(a_i), .b_i(b_i), .ps_o(tree_s), .pc_o(tree_c)
  );

  // first_i drops the stored pair in the same cycle the new product lands
  assign base_s = first_i ? '0 : st_s;
  assign base_c = first_i ? '0 : st_c;

  cs_merge #(.W(ACC_W)) u_merge (
    .acc_s_i (base_s),
    .acc_c_i (base_c),
    .prod_s_i(ACC_W'(tree_s)),
    .prod_c_i(ACC_W'(tree_c)),
    .s_o     (nx_s),
    .c_o     (nx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_s   <= '0;
      st_c   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i & last_i;
      if (valid_i) begin
        st_s <= nx_s;
        st_c <= nx_c;
      end
    end
  end

  // Single carry-propagate step, on the output only; state stays redundant
  assign result_o = st_s + (st_c << 1);
  assign done_o   = done_q;

  AST_TREE_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (tree_s + tree_c) == (PROD_W'(a_i) * PROD_W'(b_i))); // R3
  AST_ACCUMULATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !first_i) |=> result_o == $past(result_o) + ACC_W'($past(a_i)) * ACC_W'($past(b_i))); // R3
  AST_FIRST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && first_i) |=> result_o == ACC_W'($past(a_i)) * ACC_W'($past(b_i))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> done_o); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i)); // R2
endmodule

// File: tb/tb_csmac_unit.sv
module tb_csmac_unit;
  localparam int unsigned OP_W    = 8;
  localparam int unsigned GUARD_W = 4;
  localparam int unsigned ACC_W   = 2 * OP_W + GUARD_W;
  localparam int unsigned NV      = 12;

  // {valid, first, last, a, b}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 8'd3,   8'd5},
    {1'b1, 1'b0, 1'b0, 8'd10,  8'd10},
    {1'b0, 1'b1, 1'b1, 8'd200, 8'd200},
    {1'b1, 1'b0, 1'b1, 8'd7,   8'd9},
    {1'b1, 1'b0, 1'b0, 8'd2,   8'd2},
    {1'b1, 1'b1, 1'b1, 8'd255, 8'd255},
    {1'b1, 1'b1, 1'b0, 8'd0,   8'd99},
    {1'b1, 1'b0, 1'b0, 8'd128, 8'd3},
    {1'b0, 1'b0, 1'b0, 8'd1,   8'd1},
    {1'b1, 1'b0, 1'b1, 8'd1,   8'd255},
    {1'b1, 1'b1, 1'b0, 8'd17,  8'd19},
    {1'b1, 1'b0, 1'b1, 8'd255, 8'd1}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0, first_i = 1'b0, last_i = 1'b0;
  logic [OP_W-1:0]  a_i = '0, b_i = '0;
  logic [ACC_W-1:0] result_o;
  logic             done_o;

  int unsigned n_chk = 0, n_bad = 0;
  logic [ACC_W-1:0] ref_tot = '0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  csmac_unit #(.OP_W(OP_W), .GUARD_W(GUARD_W)) dut (
    .clk_i, .rst_ni, .valid_i, .first_i, .last_i, .a_i, .b_i, .result_o, .done_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the following negedge
  task automatic beat(input logic v, input logic f, input logic l,
                      input logic [7:0] a, input logic [7:0] b, input string req);
    valid_i = v; first_i = f; last_i = l; a_i = a; b_i = b;
    if (v) ref_tot = (f ? '0 : ref_tot) + ACC_W'(a) * ACC_W'(b);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " result"}, 32'(result_o), 32'(ref_tot));
    chk({req, " done"}, 32'(done_o), 32'(v & l));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 reset result", 32'(result_o), 0);
    chk("R1 reset done", 32'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-reset result", 32'(result_o), 0);
    chk("R1 post-reset done", 32'(done_o), 0);

    // Table walk: R3 accumulate, R4 restart, R5/R9 idle flags, R6 single, R8 continue, R2 done
    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0],
           $sformatf("R2/R3/R4/R5/R6/R8/R9 vec%0d", i));
    end

    // R7: 2^GUARD_W worst-case products without wraparound
    for (int k = 0; k < (1 << GUARD_W); k++) begin
      beat(1'b1, k == 0, k == (1 << GUARD_W) - 1, 8'hff, 8'hff, "R7 max run");
    end
    chk("R7 max total", 32'(result_o), 32'd1040400);

    // R9: idle cycle with flags leaves total, no done
    beat(1'b0, 1'b1, 1'b1, 8'd9, 8'd9, "R9 idle flags");
    chk("R9 total kept", 32'(result_o), 32'd1040400);

    // R8: continue after done
    beat(1'b1, 1'b0, 1'b0, 8'd4, 8'd4, "R8 continue");
    chk("R8 continued total", 32'(result_o), 32'd1040416);

    // R1: reset mid-stream clears
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset result", 32'(result_o), 0);
    chk("R1 async reset done", 32'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ref_tot = '0;
    beat(1'b1, 1'b0, 1'b1, 8'd6, 8'd7, "R3 after reset");

    finish_run();
  end
endmodule